// File: doc/BRIEF.md
# EDO Fast-Page DRAM Access Controller

This block turns single-word host requests into the strobe sequences of a 64-bit EDO DRAM bank. The bank has one row strobe, eight column strobes (one per byte lane), a shared write strobe, a shared output enable and an 11-bit multiplexed address bus. A request carries a 21-bit word address (upper 11 bits row, lower 10 bits column), eight byte enables and write data. Reads come back on a one-cycle response strobe with the captured word.

The controller keeps a row open after an access. A later request to the same row goes straight to a column cycle, which is fast page mode. A request to another row first closes the page and waits out the row precharge. Writes are always early writes: the write strobe falls before any column strobe, and the data bus is driven while the column strobes are low. Read data is latched after the column strobes have risen again. EDO parts hold their output until the next column strobe falls, so this is safe.

An external refresh arbiter raises a busy input when it needs the bank. While that input is high no request is taken, and an open page is closed. A page is also closed after a parameterised number of idle cycles, and after a parameterised total open time, so the row strobe never stays low longer than the part allows.

Top module: `edo_page_ctrl`

## Requirements
- R1: After reset the row strobe, all eight column strobes, the write strobe and the output enable are high, the data bus is not driven, no response is signalled, and a request is accepted when refresh is not busy.
- R2: A read returns the last data written to the same address. The row (req_addr[20:10]) is on the address bus when the row strobe falls. The column (req_addr[9:0]), with address bit 10 driven 0, is on the bus when the column strobes fall.
- R3: During a write only the column strobes whose byte enable is 1 fall (strobe i gates data bits 8i+7..8i). During a read all eight fall together.
- R4: A column strobe falls only while the row strobe is low, 2 to 4 cycles after the row strobe fell.
- R5: Column strobes stay low at least 2 cycles. Successive column accesses in one page start at least 3 cycles apart.
- R6: For a write, the write strobe is already low in the cycle before the column strobes fall, the output enable stays high, and the data bus is driven whenever the strobes are low.
- R7: For a read, the output enable is low before the column strobes fall, and the data bus is never driven while the output enable is low.
- R8: Consecutive accesses to the open row cause no row strobe rise and no new row activation.
- R9: An access to a different row raises the row strobe and keeps it high at least 4 cycles before the new row is opened.
- R10: While refresh_busy is high, req_ready is low, no row is activated, and an open page is closed.
- R11: With no request, an open page stays open for IDLE_LIMIT cycles and is then closed.
- R12: The row strobe stays low for at most MAX_OPEN cycles plus the length of one access, even under back-to-back same-row traffic.
- R13: Every read gives exactly one single-cycle response pulse. Writes give none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Row in bits 20:10, column in bits 9:0 |
| req_be | input | 8 | Byte enables for writes |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 64 | Read data |
| refresh_busy | input | 1 | Refresh owns the bank |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 8 | Per-lane column strobes, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_dq_out | output | 64 | Data driven to the bank |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 64 | Data returned by the bank |

## Verification
The bench targets these faults:
- Page-hit detection. A controller that compares the wrong row bits reopens the row on every access, or wrongly reuses a foreign row and returns data from it.
- Partial byte-enable writes. A wrong lane mask corrupts the neighbouring bytes on read-back.
- Refresh. If refresh does not close the page, the row strobe stays low while busy is high.
- Timers. A broken idle or age counter either closes the page too early or leaves the row strobe low far past the limit under continuous hits.
- Strobe ordering. A late write strobe, output enable asserted during writes, and a too-short precharge gap are each caught by a bank model in the bench at the strobe edges.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRECH,
    S_ROW,
    S_COLSU,
    S_STROBE,
    S_RECOV,
    S_OPEN
  } seq_state_t;

  function automatic logic row_low(input seq_state_t s);
    return (s == S_ROW) || (s == S_COLSU) || (s == S_STROBE) ||
           (s == S_RECOV) || (s == S_OPEN);
  endfunction

endpackage

// File: rtl/edo_addr_mux.sv
module edo_addr_mux #(
  parameter int ROW_W = 11,
  parameter int COL_W = 10
) (
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic             sel_row,
  output logic [ROW_W-1:0] bus
);
  generate
    if (ROW_W > COL_W) begin : g_pad
      // column phase drives the extra upper bits low
      assign bus = sel_row ? row : {{(ROW_W-COL_W){1'b0}}, col};
    end else begin : g_same
      assign bus = sel_row ? row : col[ROW_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/edo_page_tracker.sv
module edo_page_tracker #(
  parameter int ROW_W      = 11,
  parameter int IDLE_LIMIT = 64,
  parameter int MAX_OPEN   = 9000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_evt,
  input  logic [ROW_W-1:0] act_row,
  input  logic             close_evt,
  input  logic             access_evt,
  input  logic             in_open,
  input  logic [ROW_W-1:0] cmp_row,
  output logic             page_hit,
  output logic             close_due
);
  localparam int IW = $clog2(IDLE_LIMIT + 1);
  localparam int AW = $clog2(MAX_OPEN + 1);

  logic             page_valid;
  logic [ROW_W-1:0] open_row;
  logic [IW-1:0]    idle_cnt;
  logic [AW-1:0]    age_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_valid <= 1'b0;
      open_row   <= '0;
      idle_cnt   <= '0;
      age_cnt    <= '0;
    end else if (act_evt) begin
      page_valid <= 1'b1;
      open_row   <= act_row;
      idle_cnt   <= '0;
      age_cnt    <= '0;
    end else if (close_evt) begin
      page_valid <= 1'b0;
    end else begin
      if (access_evt)
        idle_cnt <= '0;
      else if (in_open && idle_cnt != IW'(IDLE_LIMIT))
        idle_cnt <= idle_cnt + 1'b1;
      if (page_valid && age_cnt != AW'(MAX_OPEN))
        age_cnt <= age_cnt + 1'b1;
    end
  end

  assign page_hit  = page_valid && (open_row == cmp_row);
  assign close_due = page_valid &&
                     ((idle_cnt == IW'(IDLE_LIMIT)) || (age_cnt == AW'(MAX_OPEN)));

  // R11
  timeout_close_chk: assert property (@(posedge clk) disable iff (rst)
    (close_due && in_open) |=> !page_valid);

endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_ctrl_pkg::*;
#(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 10,
  parameter int LANES  = 8,
  parameter int T_RCD  = 2,
  parameter int T_CASL = 2,
  parameter int T_RP   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               refresh_busy,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ROW_W-1:0]   req_row,
  input  logic [COL_W-1:0]   req_col,
  input  logic [LANES-1:0]   req_be,
  input  logic [LANES*8-1:0] req_wdata,
  output logic               req_ready,
  input  logic               page_hit,
  input  logic               close_due,
  output logic               act_evt,
  output logic [ROW_W-1:0]   act_row,
  output logic               close_evt,
  output logic               access_evt,
  output logic               in_open,
  output logic               ras_n,
  output logic [LANES-1:0]   cas_n,
  output logic               we_n,
  output logic               oe_n,
  output logic [ROW_W-1:0]   addr,
  output logic [LANES*8-1:0] dq_out,
  output logic               dq_oe,
  input  logic [LANES*8-1:0] dq_in,
  output logic               rsp_valid,
  output logic [LANES*8-1:0] rsp_rdata
);
  localparam int DW = LANES * 8;
  localparam int CW = $clog2(T_RCD + T_CASL + T_RP + 1);

  seq_state_t       state, nxt;
  logic [CW-1:0]    cnt, cnt_n;
  logic             pend, pend_n;
  logic             l_write;
  logic [ROW_W-1:0] l_row;
  logic [COL_W-1:0] l_col;
  logic [LANES-1:0] l_be;
  logic [DW-1:0]    l_wdata;
  logic             accept;

  logic             f_write;
  logic [ROW_W-1:0] f_row;
  logic [COL_W-1:0] f_col;
  logic [LANES-1:0] f_be;
  logic [DW-1:0]    f_wdata;
  logic [ROW_W-1:0] addr_n;
  logic             col_phase, drive_ph;

  assign req_ready  = !refresh_busy &&
                      ((state == S_IDLE) || ((state == S_OPEN) && !close_due));
  assign accept     = req_valid && req_ready;
  assign in_open    = (state == S_OPEN);
  assign access_evt = (state == S_RECOV);

  // fields of the access the next cycle belongs to
  assign f_write = accept ? req_write : l_write;
  assign f_row   = accept ? req_row   : l_row;
  assign f_col   = accept ? req_col   : l_col;
  assign f_be    = accept ? req_be    : l_be;
  assign f_wdata = accept ? req_wdata : l_wdata;
  assign act_row = f_row;

  always_comb begin
    nxt       = state;
    cnt_n     = cnt;
    pend_n    = pend;
    act_evt   = 1'b0;
    close_evt = 1'b0;
    case (state)
      S_IDLE: if (accept) begin
        nxt     = S_ROW;
        cnt_n   = CW'(T_RCD - 2);
        act_evt = 1'b1;
      end
      S_PRECH: begin
        if (cnt != '0) cnt_n = cnt - 1'b1;
        else if (!pend) nxt = S_IDLE;
        else if (!refresh_busy) begin
          nxt     = S_ROW;
          cnt_n   = CW'(T_RCD - 2);
          pend_n  = 1'b0;
          act_evt = 1'b1;
        end
      end
      S_ROW: begin
        if (cnt != '0) cnt_n = cnt - 1'b1;
        else nxt = S_COLSU;
      end
      S_COLSU: begin
        nxt   = S_STROBE;
        cnt_n = CW'(T_CASL - 1);
      end
      S_STROBE: begin
        if (cnt != '0) cnt_n = cnt - 1'b1;
        else nxt = S_RECOV;
      end
      S_RECOV: nxt = S_OPEN;
      S_OPEN: begin
        if (accept && page_hit) nxt = S_COLSU;
        else if (accept || close_due || refresh_busy) begin
          nxt       = S_PRECH;
          cnt_n     = CW'(T_RP - 1);
          pend_n    = accept;
          close_evt = 1'b1;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign col_phase = (nxt == S_COLSU) || (nxt == S_STROBE);
  assign drive_ph  = col_phase || (nxt == S_RECOV);

  edo_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W)) u_mux (
    .row(f_row), .col(f_col), .sel_row(nxt == S_ROW), .bus(addr_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      pend      <= 1'b0;
      l_write   <= 1'b0;
      l_row     <= '0;
      l_col     <= '0;
      l_be      <= '0;
      l_wdata   <= '0;
      ras_n     <= 1'b1;
      cas_n     <= '1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      addr      <= '0;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      state <= nxt;
      cnt   <= cnt_n;
      pend  <= pend_n;
      if (accept) begin
        l_write <= req_write;
        l_row   <= req_row;
        l_col   <= req_col;
        l_be    <= req_be;
        l_wdata <= req_wdata;
      end
      ras_n  <= !row_low(nxt);
      cas_n  <= (nxt == S_STROBE) ? (f_write ? ~f_be : '0) : '1;
      we_n   <= !(f_write && col_phase);
      dq_oe  <= f_write && col_phase;
      oe_n   <= !(!f_write && drive_ph);
      addr   <= addr_n;
      dq_out <= f_wdata;
      // EDO capture: strobes already high, bank output still held
      rsp_valid <= (state == S_RECOV) && !l_write;
      if ((state == S_RECOV) && !l_write) rsp_rdata <= dq_in;
    end
  end

  // R4
  cas_under_ras_chk: assert property (@(posedge clk) disable iff (rst)
    (cas_n != '1) |-> !ras_n);

  // R6
  early_write_chk: assert property (@(posedge clk) disable iff (rst)
    ((cas_n != '1) && $past(cas_n == '1) && !we_n) |-> $past(!we_n));

  // R7
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> !dq_oe);

  // R10
  refresh_block_chk: assert property (@(posedge clk) disable iff (rst)
    refresh_busy |-> !req_ready);

  // R13
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl #(
  parameter int ROW_W      = 11,
  parameter int COL_W      = 10,
  parameter int LANES      = 8,
  parameter int T_RCD      = 2,
  parameter int T_CASL     = 2,
  parameter int T_RP       = 4,
  parameter int IDLE_LIMIT = 64,
  parameter int MAX_OPEN   = 9000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ROW_W+COL_W-1:0]   req_addr,
  input  logic [LANES-1:0]         req_be,
  input  logic [LANES*8-1:0]       req_wdata,
  output logic                     rsp_valid,
  output logic [LANES*8-1:0]       rsp_rdata,
  input  logic                     refresh_busy,
  output logic                     dram_ras_n,
  output logic [LANES-1:0]         dram_cas_n,
  output logic                     dram_we_n,
  output logic                     dram_oe_n,
  output logic [ROW_W-1:0]         dram_addr,
  output logic [LANES*8-1:0]       dram_dq_out,
  output logic                     dram_dq_oe,
  input  logic [LANES*8-1:0]       dram_dq_in
);
  logic [ROW_W-1:0] req_row, act_row;
  logic [COL_W-1:0] req_col;
  logic page_hit, close_due, act_evt, close_evt, access_evt, in_open;

  assign req_row = req_addr[ROW_W+COL_W-1:COL_W];
  assign req_col = req_addr[COL_W-1:0];

  edo_page_tracker #(.ROW_W(ROW_W), .IDLE_LIMIT(IDLE_LIMIT), .MAX_OPEN(MAX_OPEN)) u_trk (
    .clk(clk), .rst(rst), .act_evt(act_evt), .act_row(act_row),
    .close_evt(close_evt), .access_evt(access_evt), .in_open(in_open),
    .cmp_row(req_row), .page_hit(page_hit), .close_due(close_due)
  );

  edo_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .LANES(LANES),
            .T_RCD(T_RCD), .T_CASL(T_CASL), .T_RP(T_RP)) u_seq (
    .clk(clk), .rst(rst), .refresh_busy(refresh_busy),
    .req_valid(req_valid), .req_write(req_write), .req_row(req_row),
    .req_col(req_col), .req_be(req_be), .req_wdata(req_wdata),
    .req_ready(req_ready), .page_hit(page_hit), .close_due(close_due),
    .act_evt(act_evt), .act_row(act_row), .close_evt(close_evt),
    .access_evt(access_evt), .in_open(in_open),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n), .oe_n(dram_oe_n),
    .addr(dram_addr), .dq_out(dram_dq_out), .dq_oe(dram_dq_oe),
    .dq_in(dram_dq_in), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: tb/test_edo_page_ctrl.sv
module test_edo_page_ctrl;
  localparam int IDLE_LIM = 20;
  localparam int MAX_OPN  = 60;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, refresh_busy = 1'b0;
  logic [20:0] req_addr = '0;
  logic [7:0]  req_be = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [63:0] rsp_rdata;
  logic        ras_n, we_n, oe_n, dq_oe;
  logic [7:0]  cas_n;
  logic [10:0] addr;
  logic [63:0] dq_out;
  logic [63:0] dq_in = '0;

  edo_page_ctrl #(.IDLE_LIMIT(IDLE_LIM), .MAX_OPEN(MAX_OPN)) i_edo_page_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .refresh_busy(refresh_busy), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
    .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(addr),
    .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bank model and reference store (rows/cols folded to 64 words)
  logic [63:0] mem [0:63];
  logic [63:0] ref_m [0:63];
  int cyc = 0, act_cnt = 0, rise_cnt = 0, rsp_cnt = 0;
  int ras_fall_t = 0, ras_rise_t = -100, cas_fall_t = 0, last_cas_fall = -100;
  int max_ras_low = 0;
  bit first_cas = 0, had_rise = 0;
  logic prev_ras = 1'b1, prev_we = 1'b1, prev_oe = 1'b1;
  logic [7:0] prev_cas = 8'hFF, last_mask = 8'hFF;
  logic [10:0] last_row = '0, last_coladdr = '0;
  logic [10:0] cur_row = '0;

  initial for (int i = 0; i < 64; i++) begin mem[i] = '0; ref_m[i] = '0; end

  always @(negedge clk) begin
    cyc++;
    if (rsp_valid) rsp_cnt++;
    if (prev_ras && !ras_n) begin
      act_cnt++; cur_row = addr; last_row = addr; ras_fall_t = cyc; first_cas = 1;
      // R9 precharge at least 4 cycles
      if (had_rise) chk(cyc - ras_rise_t >= 4, "R9 precharge", 64'(cyc - ras_rise_t), 64'd4);
    end
    if (!prev_ras && ras_n) begin
      rise_cnt++; ras_rise_t = cyc; had_rise = 1;
      if (cyc - ras_fall_t > max_ras_low) max_ras_low = cyc - ras_fall_t;
    end
    if (prev_cas == 8'hFF && cas_n != 8'hFF) begin
      last_mask = cas_n; last_coladdr = addr; cas_fall_t = cyc;
      if (first_cas) begin
        chk((cyc - ras_fall_t >= 2) && (cyc - ras_fall_t <= 4), "R4 ras-to-cas", 64'(cyc - ras_fall_t), 64'd2);
        first_cas = 0;
      end else
        chk(cyc - last_cas_fall >= 3, "R5 page cycle", 64'(cyc - last_cas_fall), 64'd3);
      last_cas_fall = cyc;
      if (!we_n) begin
        chk(!prev_we && oe_n && dq_oe, "R6 early write", {61'd0, prev_we, oe_n, dq_oe}, 64'b011);
        for (int l = 0; l < 8; l++)
          if (!cas_n[l]) mem[{cur_row[1:0], addr[3:0]}][l*8 +: 8] = dq_out[l*8 +: 8];
      end else begin
        chk(!prev_oe && !dq_oe, "R7 read enable", {62'd0, prev_oe, dq_oe}, 64'd0);
        dq_in = mem[{cur_row[1:0], addr[3:0]}];
      end
    end
    if (prev_cas != 8'hFF && cas_n == 8'hFF)
      chk(cyc - cas_fall_t >= 2, "R5 cas low width", 64'(cyc - cas_fall_t), 64'd2);
    prev_ras = ras_n; prev_cas = cas_n; prev_we = we_n; prev_oe = oe_n;
  end

  task automatic send(input bit wr, input logic [10:0] row, input logic [9:0] col,
                      input logic [7:0] be, input logic [63:0] d);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = {row, col}; req_be = be; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [10:0] row, input logic [9:0] col,
                    input logic [7:0] be, input logic [63:0] d);
    send(1'b1, row, col, be, d);
    for (int l = 0; l < 8; l++)
      if (be[l]) ref_m[{row[1:0], col[3:0]}][l*8 +: 8] = d[l*8 +: 8];
    repeat (5) @(negedge clk);
  endtask

  task automatic rd_chk(input logic [10:0] row, input logic [9:0] col, input string req);
    logic [63:0] got;
    int n;
    got = 'x; n = 0;
    send(1'b0, row, col, 8'h00, 64'd0);
    while (!rsp_valid && n < 20) begin @(negedge clk); n++; end
    got = rsp_rdata;
    chk(rsp_valid && got === ref_m[{row[1:0], col[3:0]}], req, got, ref_m[{row[1:0], col[3:0]}]);
  endtask

  task automatic settle();
    repeat (IDLE_LIM + 12) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ras_n && cas_n == 8'hFF && we_n && oe_n && !dq_oe && !rsp_valid && req_ready,
        "R1 reset state", {52'd0, ras_n, cas_n, we_n, oe_n, dq_oe, rsp_valid, req_ready},
        {52'd0, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1});
  endtask

  task automatic t_basic();
    wr(11'h402, 10'h3, 8'hFF, 64'h0123_4567_89AB_CDEF);
    chk(last_row == 11'h402, "R2 row on bus", 64'(last_row), 64'h402);
    rd_chk(11'h402, 10'h3, "R2 read back");
    chk(last_coladdr == 11'h003, "R2 column with bit10 low", 64'(last_coladdr), 64'h3);
    wr(11'h001, 10'h2C5, 8'hFF, 64'hDEAD_BEEF_0000_1111);
    rd_chk(11'h001, 10'h2C5, "R2 second pattern");
  endtask

  task automatic t_bytes();
    wr(11'h003, 10'h7, 8'hFF, 64'hAAAA_AAAA_AAAA_AAAA);
    wr(11'h003, 10'h7, 8'h5A, 64'h1122_3344_5566_7788);
    chk(last_mask == 8'hA5, "R3 write lane mask", 64'(last_mask), 64'hA5);
    rd_chk(11'h003, 10'h7, "R3 merged bytes");
    chk(last_mask == 8'h00, "R3 read lane mask", 64'(last_mask), 64'h00);
  endtask

  task automatic t_page_hit();
    int a0, r0;
    settle();
    rd_chk(11'h002, 10'h1, "R8 first access");
    a0 = act_cnt; r0 = rise_cnt;
    wr(11'h002, 10'h5, 8'h0F, 64'h0000_0000_CAFE_F00D);
    rd_chk(11'h002, 10'h5, "R8 hit read");
    rd_chk(11'h002, 10'h1, "R8 hit read 2");
    chk(act_cnt == a0 && rise_cnt == r0, "R8 no reactivation",
        64'(act_cnt - a0 + rise_cnt - r0), 64'd0);
  endtask

  task automatic t_page_miss();
    int a0, r0;
    rd_chk(11'h002, 10'h5, "R9 open row");
    a0 = act_cnt; r0 = rise_cnt;
    rd_chk(11'h001, 10'h2C5, "R9 other row data");
    chk(act_cnt == a0 + 1 && rise_cnt == r0 + 1, "R9 close then open",
        64'(act_cnt - a0), 64'd1);
  endtask

  task automatic t_refresh();
    int a0;
    rd_chk(11'h003, 10'h7, "R10 open before refresh");
    @(posedge clk); #1; refresh_busy = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R10 ready low", 64'(req_ready), 64'd0);
    a0 = act_cnt;
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = 1'b0; req_addr = {11'h001, 10'h2C5};
    repeat (10) @(negedge clk);
    chk(ras_n && act_cnt == a0, "R10 page closed, no activation", 64'(act_cnt - a0), 64'd0);
    @(posedge clk); #1; req_valid = 1'b0; refresh_busy = 1'b0;
    rd_chk(11'h001, 10'h2C5, "R10 after refresh");
  endtask

  task automatic t_idle();
    settle();
    rd_chk(11'h000, 10'h0, "R11 open page");
    repeat (IDLE_LIM - 6) @(negedge clk);
    chk(!ras_n, "R11 still open before limit", 64'(ras_n), 64'd0);
    repeat (16) @(negedge clk);
    chk(ras_n, "R11 closed after limit", 64'(ras_n), 64'd1);
  endtask

  task automatic t_age();
    int r0;
    settle();
    r0 = rise_cnt; max_ras_low = 0;
    for (int i = 0; i < 25; i++) rd_chk(11'h002, 10'(i % 8), "R12 data under hits");
    settle();
    chk(rise_cnt - r0 >= 2, "R12 forced close", 64'(rise_cnt - r0), 64'd2);
    chk(max_ras_low <= MAX_OPN + 10, "R12 ras low bound", 64'(max_ras_low), 64'(MAX_OPN + 10));
  endtask

  task automatic t_rsp();
    int c0;
    c0 = rsp_cnt;
    wr(11'h001, 10'h9, 8'hFF, 64'h5555_0000_5555_0000);
    wr(11'h001, 10'hA, 8'h81, 64'hFF00_0000_0000_00FF);
    repeat (4) @(negedge clk);
    chk(rsp_cnt == c0, "R13 no response on write", 64'(rsp_cnt - c0), 64'd0);
    rd_chk(11'h001, 10'h9, "R13 read data");
    repeat (4) @(negedge clk);
    chk(rsp_cnt == c0 + 1, "R13 one pulse per read", 64'(rsp_cnt - c0), 64'd1);
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_basic();
    t_bytes();
    t_page_hit();
    t_page_miss();
    t_refresh();
    t_idle();
    t_age();
    t_rsp();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule